// File: doc/BRIEF.md
# Two-Lane Priority Message Channel

This block carries coherence messages one way between a cache and the home node. Every message carries a source id, a destination id, a command, an address and a data word. The top bit of the command picks the priority. Replies, which are the shared, exclusive, invalidate, writeback and flush acknowledgements, set that bit and travel on the high lane. Requests, which are the shared, exclusive, invalidate, writeback and flush requests, clear it and travel on the low lane.

Each lane is its own FIFO. Within a lane, messages leave in the order they were accepted. The two lanes never block each other, so a backlog of requests that the consumer cannot serve yet does not hold back a reply. The consumer sees two separate valid/ready delivery ports. It can therefore take replies while requests stall.

When both lanes hold messages, the high lane wins. The low lane is offered only when the high lane is empty, or when its consumer is taking a high message in the same cycle.

Top module: `prio_msg_channel`

## Requirements
- R1: After reset, both lanes are empty. `hi_valid` and `lo_valid` are 0, and `in_ready` is 1.
- R2: A message whose command top bit `in_cmd[CMD_W-1]` is 1 goes to the high lane. A message whose top bit is 0 goes to the low lane.
- R3: Within each lane, messages are delivered in the order they were accepted.
- R4: `in_ready` is 0 only when the lane selected by `in_cmd[CMD_W-1]` is full. A full lane never blocks a message bound for the other lane.
- R5: A message accepted into an empty lane appears on that lane's output in the next cycle.
- R6: `lo_valid` is 1 exactly when the low lane holds a message and either the high lane is empty or `hi_ready` is 1.
- R7: `hi_valid` is 1 whenever the high lane holds a message, whatever the state of the low lane.
- R8: While a lane's output is stalled, that lane's head message stays unchanged.
- R9: Each lane accepts exactly DEPTH messages before it reports full.
- R10: Every field, in the order source, destination, command, address, data, is delivered unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input message valid |
| in_ready | output | 1 | Selected lane can accept the message |
| in_src | input | SRC_W | Source id |
| in_dst | input | DST_W | Destination id |
| in_cmd | input | CMD_W | Command; top bit 1 means high priority |
| in_addr | input | ADDR_W | Address |
| in_data | input | DATA_W | Data value |
| hi_valid | output | 1 | High lane head valid |
| hi_ready | input | 1 | Consumer takes the high head |
| hi_src | output | SRC_W | High head source id |
| hi_dst | output | DST_W | High head destination id |
| hi_cmd | output | CMD_W | High head command |
| hi_addr | output | ADDR_W | High head address |
| hi_data | output | DATA_W | High head data |
| lo_valid | output | 1 | Low lane head offered |
| lo_ready | input | 1 | Consumer takes the low head |
| lo_src | output | SRC_W | Low head source id |
| lo_dst | output | DST_W | Low head destination id |
| lo_cmd | output | CMD_W | Low head command |
| lo_addr | output | ADDR_W | Low head address |
| lo_data | output | DATA_W | Low head data |

## Verification
The checks assume the producer keeps its message fields meaningful whenever `in_valid` is high. They also assume each ready input is a plain per-cycle decision that does not depend on the same lane's valid. The stimulus sets fresh random fields and ready values once per cycle, away from the clock edge, and never takes them back within the cycle. The directed phases drive `hi_ready` low for long stretches while low and high messages keep arriving. This fills each lane to its limit and exercises the gating of the low lane.

// File: rtl/prio_msg_channel.sv
module prio_msg_channel #(
  parameter int SRC_W  = 4,
  parameter int DST_W  = 4,
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [DST_W-1:0]  in_dst,
  input  logic [CMD_W-1:0]  in_cmd,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              hi_valid,
  input  logic              hi_ready,
  output logic [SRC_W-1:0]  hi_src,
  output logic [DST_W-1:0]  hi_dst,
  output logic [CMD_W-1:0]  hi_cmd,
  output logic [ADDR_W-1:0] hi_addr,
  output logic [DATA_W-1:0] hi_data,
  output logic              lo_valid,
  input  logic              lo_ready,
  output logic [SRC_W-1:0]  lo_src,
  output logic [DST_W-1:0]  lo_dst,
  output logic [CMD_W-1:0]  lo_cmd,
  output logic [ADDR_W-1:0] lo_addr,
  output logic [DATA_W-1:0] lo_data
);
  localparam int MSG_W = SRC_W + DST_W + CMD_W + ADDR_W + DATA_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             in_hi;
  logic [MSG_W-1:0] in_msg;
  logic [MSG_W-1:0] head [2];
  logic [1:0]       full, nonempty, push, pop;

  assign in_hi  = in_cmd[CMD_W-1];
  assign in_msg = {in_src, in_dst, in_cmd, in_addr, in_data};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [MSG_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;

    assign push[g]     = in_valid & in_ready & (in_hi == (g == 1));
    assign full[g]     = (cnt == CNT_W'(DEPTH));
    assign nonempty[g] = (cnt != '0);
    assign head[g]     = mem[rd_ptr];

    always_ff @(posedge clk) begin
      if (push[g]) mem[wr_ptr] <= in_msg;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        cnt    <= '0;
      end else begin
        if (push[g]) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        if (pop[g])  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        cnt <= cnt + CNT_W'(push[g]) - CNT_W'(pop[g]);
      end
    end
  end

  assign in_ready = in_hi ? !full[1] : !full[0];

  assign hi_valid = nonempty[1];
  assign lo_valid = nonempty[0] & (!nonempty[1] | hi_ready);
  assign pop[1]   = hi_valid & hi_ready;
  assign pop[0]   = lo_valid & lo_ready;

  assign {hi_src, hi_dst, hi_cmd, hi_addr, hi_data} = head[1];
  assign {lo_src, lo_dst, lo_cmd, lo_addr, lo_data} = head[0];
endmodule

// File: rtl/prio_msg_channel_chk.sv
module prio_msg_channel_chk #(
  parameter int CMD_W  = 4,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CMD_W-1:0]  in_cmd,
  input logic              hi_valid,
  input logic              hi_ready,
  input logic [CMD_W-1:0]  hi_cmd,
  input logic [DATA_W-1:0] hi_data,
  input logic              lo_valid,
  input logic              lo_ready,
  input logic [CMD_W-1:0]  lo_cmd,
  input logic [DATA_W-1:0] lo_data
);
  int hc, lc;
  logic hi_in, lo_in;

  assign hi_in = in_valid & in_ready &  in_cmd[CMD_W-1];
  assign lo_in = in_valid & in_ready & !in_cmd[CMD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc <= 0;
      lc <= 0;
    end else begin
      hc <= hc + int'(hi_in) - int'(hi_valid & hi_ready);
      lc <= lc + int'(lo_in) - int'(lo_valid & lo_ready);
    end
  end

  // R1
  r1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hc == 0 && lc == 0) |-> (!hi_valid && !lo_valid && in_ready));

  // R4
  in_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (in_cmd[CMD_W-1] ? hc == DEPTH : lc == DEPTH));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hc <= DEPTH && lc <= DEPTH);

  // R7
  hi_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hc != 0) |-> hi_valid);

  // R6
  lo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid |-> (!hi_valid || hi_ready));

  // R2
  lane_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_valid |-> hi_cmd[CMD_W-1]) and (lo_valid |-> !lo_cmd[CMD_W-1]));

  // R5
  hi_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_in |=> hi_valid);

  // R8
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_valid && !hi_ready) |=> (hi_valid && $stable(hi_data) && $stable(hi_cmd)));

  // R8
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_valid && !lo_ready) |=> ($stable(lo_data) && $stable(lo_cmd)));
endmodule

bind prio_msg_channel prio_msg_channel_chk #(
  .CMD_W(CMD_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_chk (.*);

// File: tb/test_prio_msg_channel.sv
`timescale 1ns/1ps
module test_prio_msg_channel;
  localparam int SW = 4, DW = 4, CW = 4, AW = 16, VW = 32, DEPTH = 4;
  localparam int MW = SW + DW + CW + AW + VW;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [SW-1:0] in_src = '0;
  logic [DW-1:0] in_dst = '0;
  logic [CW-1:0] in_cmd = '0;
  logic [AW-1:0] in_addr = '0;
  logic [VW-1:0] in_data = '0;
  logic hi_valid, hi_ready = 0, lo_valid, lo_ready = 0;
  logic [SW-1:0] hi_src, lo_src;
  logic [DW-1:0] hi_dst, lo_dst;
  logic [CW-1:0] hi_cmd, lo_cmd;
  logic [AW-1:0] hi_addr, lo_addr;
  logic [VW-1:0] hi_data, lo_data;

  int checks = 0, fails = 0;
  logic [MW-1:0] hq[$], lq[$];

  always #2.5 clk = ~clk;

  prio_msg_channel #(.SRC_W(SW), .DST_W(DW), .CMD_W(CW), .ADDR_W(AW),
                     .DATA_W(VW), .DEPTH(DEPTH)) i_prio_msg_channel (.*);

  task automatic check(input bit ok, input string tag,
                       input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [MW-1:0] hi_msg();
    return {hi_src, hi_dst, hi_cmd, hi_addr, hi_data};
  endfunction
  function automatic logic [MW-1:0] lo_msg();
    return {lo_src, lo_dst, lo_cmd, lo_addr, lo_data};
  endfunction
  function automatic bit exp_lo(input bit hr);
    return lq.size() != 0 && (hq.size() == 0 || hr);
  endfunction
  function automatic bit exp_rdy(input bit hi);
    return hi ? hq.size() < DEPTH : lq.size() < DEPTH;
  endfunction

  task automatic cyc(input bit v, input bit hi, input bit hr, input bit lr);
    bit hv, lv, rdy;
    @(negedge clk);
    in_valid = v;
    in_src   = SW'($urandom);
    in_dst   = DW'($urandom);
    in_cmd   = {hi, (CW-1)'($urandom)};
    in_addr  = AW'($urandom);
    in_data  = VW'($urandom);
    hi_ready = hr;
    lo_ready = lr;
    #1;
    check(hi_valid == (hq.size() != 0), "R5 R7 hi_valid", MW'(hi_valid), MW'(hq.size() != 0));
    if (hq.size() != 0 && hi_valid)
      check(hi_msg() == hq[0], "R2 R3 R8 R10 hi head", hi_msg(), hq[0]);
    check(lo_valid == exp_lo(hr), "R6 lo_valid", MW'(lo_valid), MW'(exp_lo(hr)));
    if (lq.size() != 0 && lo_valid)
      check(lo_msg() == lq[0], "R2 R3 R8 R10 lo head", lo_msg(), lq[0]);
    check(in_ready == exp_rdy(hi), "R4 R9 in_ready", MW'(in_ready), MW'(exp_rdy(hi)));
    hv = hi_valid; lv = lo_valid; rdy = in_ready;
    if (hv && hr) void'(hq.pop_front());
    if (lv && lr) void'(lq.pop_front());
    if (v && rdy) begin
      if (hi) hq.push_back({in_src, in_dst, in_cmd, in_addr, in_data});
      else    lq.push_back({in_src, in_dst, in_cmd, in_addr, in_data});
    end
  endtask

  bit done = 0;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(!hi_valid && !lo_valid && in_ready, "R1 reset state",
          MW'({hi_valid, lo_valid, in_ready}), MW'(3'b001));
    // R9: fill high lane past depth while the consumer stalls
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, 1, 0, 1);
    // R4 R6: low messages accepted but not offered while high is stalled
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, 0, 0, 1);
    for (int i = 0; i < 3 * DEPTH; i++) cyc(0, 0, 1, 1);
    // R6: low lane full, high traffic keeps flowing
    for (int i = 0; i < DEPTH + 1; i++) cyc(1, 0, 1, 0);
    for (int i = 0; i < 20; i++) cyc(1, 1, 1, 0);
    for (int i = 0; i < 3 * DEPTH; i++) cyc(0, 0, 1, 1);
    // constrained random traffic
    for (int i = 0; i < 6000; i++)
      cyc(($urandom % 4) != 0, $urandom % 2, ($urandom % 3) != 0, ($urandom % 2) != 0);
    for (int i = 0; i < 4000; i++)
      cyc(1, ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 5) == 0);
    for (int i = 0; i < 3 * DEPTH; i++) cyc(0, 0, 1, 1);
    check(hq.size() == 0 && lq.size() == 0 && !hi_valid && !lo_valid, "R3 drained",
          MW'({hi_valid, lo_valid}), '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule